// File: doc/BRIEF.md
# Bus Time-Slot Sequencer with RAM-Only Turbo

This block divides every 1 MHz bus cycle of a small home-computer system into 32 sub-slots of a 32 MHz system clock. From a free-running slot counter it derives single-cycle enable strobes for three users of the shared bus: the video controller, the processor and the serial port logic. It also drives the 1 MHz phase clock and a flag that marks when the processor owns the bus. Each output is registered, so all of them change on the same edge as the slot counter.

A turbo mode gives the processor a second access in every bus cycle. That extra access is granted only when the access decodes to main RAM. Peripheral registers therefore keep the timing they get from the phase clock. An active-low DMA request removes every processor grant, which hands the bus to an external master. Address decoding, the processor, the video controller and memory sit outside this block.

Slot map, with slot numbers as seen on `slot_idx`: slots 0–7 are idle, 8–11 belong to the serial port, 12–15 to video, and 16–31 are processor slots 0x0 to 0xF.

Top module: `bus_slot_sequencer`

## Requirements
- R1: `slot_idx` counts 0, 1, …, 31 and then wraps to 0, advancing by one on every clock edge.
- R2: `ser_en` is high only in slot 8. `vid_en` is high only in slots 14 and 30, which are video slot 2 and processor slot 0xE.
- R3: With turbo latched off, `cpu_en` is high at most once per bus cycle, in slot 30 (processor slot 0xE).
- R4: With turbo latched on, an extra `cpu_en` pulse appears in slot 26 (processor slot 0xA). It appears only if `ram_select` is high in both slot 24 and slot 25. It never appears when `ram_select` is low in slot 25.
- R5: `turbo_en` is sampled only while `slot_idx` is 0. A change at any other time first takes effect in the next bus cycle.
- R6: When `dma_n` is low in either of the two slots before a processor strobe slot (slots 28/29 for slot 30, slots 24/25 for slot 26), that strobe and its bus ownership are withheld.
- R7: `cpu_owns_bus` is high in the slot before each granted `cpu_en` pulse and in the pulse slot itself (slots 29–30, plus 25–26 when a turbo access is granted). It is low everywhere else.
- R8: `phase_clk` is low in slots 0–15 and high in slots 16–31.
- R9: While `rst` is high, on the following edge `slot_idx` is 0 and every strobe, `cpu_owns_bus` and `phase_clk` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| turbo_en | input | 1 | Requests the extra RAM-only processor slot |
| ram_select | input | 1 | Current processor access decodes to main RAM |
| dma_n | input | 1 | Active-low external bus request; blocks processor grants |
| ser_en | output | 1 | Serial port enable strobe |
| vid_en | output | 1 | Video controller enable strobe |
| cpu_en | output | 1 | Processor enable strobe |
| cpu_owns_bus | output | 1 | Processor holds the bus |
| phase_clk | output | 1 | 1 MHz phase clock |
| slot_idx | output | 5 | Current slot number, 0–31 |

## Verification
The bench drives turbo high partway through a bus cycle. A design that sampled it at the wrong time would give a partly accelerated cycle with two processor strobes. It also holds `ram_select` high for exactly one of the two sampling slots before slot 26. A design that checked RAM too early or too late would grant the turbo strobe to a peripheral access, or miss a valid RAM access. A one-slot DMA pulse just before slot 30 checks that a single low sample removes the strobe and the ownership flag, rather than letting them through one cycle late. Reset is applied in the middle of a cycle to show that the counter restarts at slot 0 with every output low.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef struct packed {
        logic ser;
        logic vid;
        logic cpu;
        logic own;
        logic phi;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ser: 1'b0, vid: 1'b0, cpu: 1'b0, own: 1'b0, phi: 1'b0};

endpackage

// File: rtl/bus_slot_counter.sv
module bus_slot_counter #(
    parameter int SLOTS = 32,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot_q,
    output logic [SW-1:0] slot_d
);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    always_comb begin
        if (rst)                 slot_d = '0;
        else if (slot_q == LAST) slot_d = '0;
        else                     slot_d = slot_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        slot_q <= slot_d;
    end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_seq_pkg::*;
#(
    parameter int SLOTS        = 32,
    parameter int IDLE_SLOTS   = 8,
    parameter int SER_SLOTS    = 4,
    parameter int VID_SLOTS    = 4,
    parameter int SER_SUB      = 0,
    parameter int VID_SUB      = 2,
    parameter int CPU_MAIN_SUB = 14,
    parameter int CPU_FAST_SUB = 10,
    localparam int SW          = $clog2(SLOTS)
) (
    input  logic [SW-1:0] slot_nx,
    input  logic          turbo_q,
    input  logic          ram_select,
    input  logic          dma_n,
    input  logic          own_q,
    output strobe_t       strb_nx
);
    localparam int SER_BASE = IDLE_SLOTS;
    localparam int VID_BASE = SER_BASE + SER_SLOTS;
    localparam int CPU_BASE = VID_BASE + VID_SLOTS;

    localparam logic [SW-1:0] S_SER       = SW'(SER_BASE + SER_SUB);
    localparam logic [SW-1:0] S_VID       = SW'(VID_BASE + VID_SUB);
    localparam logic [SW-1:0] S_MAIN      = SW'(CPU_BASE + CPU_MAIN_SUB);
    localparam logic [SW-1:0] S_MAIN_PRE  = SW'(CPU_BASE + CPU_MAIN_SUB - 1);
    localparam logic [SW-1:0] S_FAST      = SW'(CPU_BASE + CPU_FAST_SUB);
    localparam logic [SW-1:0] S_FAST_PRE  = SW'(CPU_BASE + CPU_FAST_SUB - 1);
    localparam logic [SW-1:0] S_CPU_FIRST = SW'(CPU_BASE);

    logic main_pre, main_hit, fast_pre, fast_hit;

    always_comb begin
        main_pre = (slot_nx == S_MAIN_PRE) && dma_n;
        main_hit = (slot_nx == S_MAIN)     && dma_n && own_q;
        fast_pre = (slot_nx == S_FAST_PRE) && turbo_q && ram_select && dma_n;
        fast_hit = (slot_nx == S_FAST)     && turbo_q && ram_select && dma_n && own_q;

        strb_nx     = STROBE_IDLE;
        strb_nx.ser = (slot_nx == S_SER);
        strb_nx.vid = (slot_nx == S_VID) || (slot_nx == S_MAIN);
        strb_nx.cpu = main_hit || fast_hit;
        strb_nx.own = main_pre || main_hit || fast_pre || fast_hit;
        strb_nx.phi = (slot_nx >= S_CPU_FIRST);
    end
endmodule

// File: rtl/bus_slot_sequencer.sv
module bus_slot_sequencer
    import bus_seq_pkg::*;
#(
    parameter int SLOTS        = 32,
    parameter int IDLE_SLOTS   = 8,
    parameter int SER_SLOTS    = 4,
    parameter int VID_SLOTS    = 4,
    parameter int SER_SUB      = 0,
    parameter int VID_SUB      = 2,
    parameter int CPU_MAIN_SUB = 14,
    parameter int CPU_FAST_SUB = 10,
    localparam int SW          = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          turbo_en,
    input  logic          ram_select,
    input  logic          dma_n,
    output logic          ser_en,
    output logic          vid_en,
    output logic          cpu_en,
    output logic          cpu_owns_bus,
    output logic          phase_clk,
    output logic [SW-1:0] slot_idx
);
    typedef struct packed {
        strobe_t strb;
        logic    turbo;
    } seq_state_t;

    seq_state_t    st_d, st_q;
    logic [SW-1:0] slot_q, slot_d;
    strobe_t       strb_nx;

    bus_slot_counter #(.SLOTS(SLOTS)) i_cnt (
        .clk    (clk),
        .rst    (rst),
        .slot_q (slot_q),
        .slot_d (slot_d)
    );

    bus_strobe_gen #(
        .SLOTS        (SLOTS),
        .IDLE_SLOTS   (IDLE_SLOTS),
        .SER_SLOTS    (SER_SLOTS),
        .VID_SLOTS    (VID_SLOTS),
        .SER_SUB      (SER_SUB),
        .VID_SUB      (VID_SUB),
        .CPU_MAIN_SUB (CPU_MAIN_SUB),
        .CPU_FAST_SUB (CPU_FAST_SUB)
    ) i_gen (
        .slot_nx    (slot_d),
        .turbo_q    (st_q.turbo),
        .ram_select (ram_select),
        .dma_n      (dma_n),
        .own_q      (st_q.strb.own),
        .strb_nx    (strb_nx)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.strb  = STROBE_IDLE;
            st_d.turbo = 1'b0;
        end else begin
            st_d.strb = strb_nx;
            if (slot_q == '0) st_d.turbo = turbo_en;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ser_en       = st_q.strb.ser;
    assign vid_en       = st_q.strb.vid;
    assign cpu_en       = st_q.strb.cpu;
    assign cpu_owns_bus = st_q.strb.own;
    assign phase_clk    = st_q.strb.phi;
    assign slot_idx     = slot_q;
endmodule

// File: rtl/bus_slot_sequencer_chk.sv
module bus_slot_sequencer_chk #(
    parameter int SW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          ram_select,
    input logic          dma_n,
    input logic          ser_en,
    input logic          vid_en,
    input logic          cpu_en,
    input logic          cpu_owns_bus,
    input logic          phase_clk,
    input logic [SW-1:0] slot_idx
);
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (slot_idx == SW'(31)) |=> (slot_idx == '0));

    a_r2_serial_pos: assert property (@(posedge clk) disable iff (rst)
        ser_en |-> (slot_idx == SW'(8)));

    a_r2_video_pos: assert property (@(posedge clk) disable iff (rst)
        vid_en |-> (slot_idx == SW'(14) || slot_idx == SW'(30)));

    a_r3_cpu_pos: assert property (@(posedge clk) disable iff (rst)
        cpu_en |-> (slot_idx == SW'(30) || slot_idx == SW'(26)));

    a_r4_fast_needs_ram: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && slot_idx == SW'(26)) |-> $past(ram_select));

    a_r6_dma_blocks: assert property (@(posedge clk) disable iff (rst)
        (!$past(dma_n)) |-> !cpu_en);

    a_r7_own_leads: assert property (@(posedge clk) disable iff (rst)
        cpu_en |-> (cpu_owns_bus && $past(cpu_owns_bus)));

    a_r8_phase: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_clk) |-> (slot_idx == SW'(16)));
endmodule

bind bus_slot_sequencer bus_slot_sequencer_chk #(.SW(SW)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .ram_select   (ram_select),
    .dma_n        (dma_n),
    .ser_en       (ser_en),
    .vid_en       (vid_en),
    .cpu_en       (cpu_en),
    .cpu_owns_bus (cpu_owns_bus),
    .phase_clk    (phase_clk),
    .slot_idx     (slot_idx)
);

// File: tb/test_bus_slot_sequencer.sv
module test_bus_slot_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       turbo_en = 1'b0, ram_select = 1'b0, dma_n = 1'b1;
    logic       ser_en, vid_en, cpu_en, cpu_owns_bus, phase_clk;
    logic [4:0] slot_idx;
    int         total = 0, bad = 0;

    always #4 clk = ~clk;

    bus_slot_sequencer i_bus_slot_sequencer (
        .clk(clk), .rst(rst), .turbo_en(turbo_en), .ram_select(ram_select), .dma_n(dma_n),
        .ser_en(ser_en), .vid_en(vid_en), .cpu_en(cpu_en), .cpu_owns_bus(cpu_owns_bus),
        .phase_clk(phase_clk), .slot_idx(slot_idx)
    );

    // fields: [4] turbo, [3] ram, [2] dma_n, [1:0] expected cpu strobes per cycle
    localparam logic [4:0] VEC [10] = '{
        5'b0_0_1_01, 5'b0_1_1_01, 5'b1_0_1_01, 5'b1_1_1_10, 5'b1_1_0_00,
        5'b0_1_0_00, 5'b1_1_1_10, 5'b1_0_0_00, 5'b0_0_1_01, 5'b1_1_1_10
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (slot %0d)", req, act, exp, slot_idx);
        end
    endtask

    task automatic to_slot(input int s);
        while (int'(slot_idx) != s) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 slot", slot_idx, 0);
        chk("R9 outputs", {ser_en, vid_en, cpu_en, cpu_owns_bus, phase_clk}, 0);
        rst = 1'b0;

        foreach (VEC[v]) begin
            bit t, r, d;
            t = VEC[v][4]; r = VEC[v][3]; d = VEC[v][2];
            to_slot(31);
            turbo_en = t; ram_select = r; dma_n = d;
            cnt = 0;
            for (int k = 0; k < 32; k++) begin
                bit fast, e_cpu, e_own;
                @(negedge clk);
                fast  = t && r && d;
                e_cpu = d && (k == 30 || (fast && k == 26));
                e_own = d && (k == 29 || k == 30 || (fast && (k == 25 || k == 26)));
                chk("R1 slot", slot_idx, k);
                chk("R2 serial", ser_en, int'(k == 8));
                chk("R2 video", vid_en, int'(k == 14 || k == 30));
                chk(t ? "R4 cpu" : "R3 cpu", cpu_en, int'(e_cpu));
                chk(d ? "R7 own" : "R6 own", cpu_owns_bus, int'(e_own));
                chk("R8 phase", phase_clk, int'(k >= 16));
                cnt += int'(cpu_en);
            end
            chk("R3/R4 strobes per cycle", cnt, int'(VEC[v][1:0]));
        end

        // R5: turbo raised mid-cycle must not accelerate the current cycle
        to_slot(31);
        turbo_en = 1'b0; ram_select = 1'b1; dma_n = 1'b1;
        to_slot(5);
        turbo_en = 1'b1;
        cnt = 0;
        while (int'(slot_idx) != 31) begin @(negedge clk); cnt += int'(cpu_en); end
        chk("R5 mid-cycle turbo", cnt, 1);
        cnt = 0;
        for (int k = 0; k < 32; k++) begin @(negedge clk); cnt += int'(cpu_en); end
        chk("R5 next cycle turbo", cnt, 2);

        // R6: one-slot dma pulse in slot 29 kills slot 30 strobe and ownership
        to_slot(29);
        chk("R7 own before strobe", cpu_owns_bus, 1);
        dma_n = 1'b0;
        @(negedge clk);
        dma_n = 1'b1;
        chk("R6 dma pulse cpu", cpu_en, 0);
        chk("R6 dma pulse own", cpu_owns_bus, 0);

        // R4: ram only in slots 24..25 still earns the fast strobe
        to_slot(23);
        ram_select = 1'b0;
        to_slot(24);
        ram_select = 1'b1;
        @(negedge clk);
        chk("R4 own slot 25", cpu_owns_bus, 1);
        @(negedge clk);
        ram_select = 1'b0;
        chk("R4 fast strobe granted", cpu_en, 1);

        // R4: ram high in slot 24 but low in slot 25 gives no fast strobe
        to_slot(24);
        ram_select = 1'b1;
        @(negedge clk);
        ram_select = 1'b0;
        chk("R4 own slot 25 early ram", cpu_owns_bus, 1);
        @(negedge clk);
        chk("R4 fast strobe refused", cpu_en, 0);
        chk("R7 own dropped", cpu_owns_bus, 0);

        // R9: reset mid-cycle
        to_slot(20);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid reset slot", slot_idx, 0);
        chk("R9 mid reset outputs", {ser_en, vid_en, cpu_en, cpu_owns_bus, phase_clk}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 restart", slot_idx, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule